// File: doc/BRIEF.md
# Bridge PWM Output Steering

This block makes one pulse-width-modulated waveform from a free-running period counter and a 10-bit duty value, then routes it onto four output channels, A, B, C and D. A 2-bit steering code picks how the channels are used: one modulated channel, a complementary half-bridge pair with a fixed dead band, or a full bridge that runs forward or in reverse. In the full-bridge modes one channel is modulated and another is held at its active level. Each channel has an output-enable line. A channel that the selected steering does not use has its enable low, so the pin can serve as general-purpose I/O.

A 2-bit polarity code sets the active level of two channel groups, A/C and B/D. The steering, polarity, duty and dead-band values are shadowed. They move into the working registers only when a new period begins. When PWM operation is off, channel A carries a capture/compare pin signal that arrives on two pass-through inputs, and channels B to D are released. The period counter is an 8-bit timer extended by a 2-bit fraction. The waveform is active while that 10-bit count is below the duty value.

Top module: `bridge_pwm_steer`

## Requirements
- R1: While reset is held, and after reset until PWM is enabled, channels B to D have output enable low and output 0, and channel A reflects `ccpOut`/`ccpOe`.
- R2: One period lasts 4*(`periodIn`+1) clock cycles. The logical active time per period is min(duty, period length), where duty is {`dutyHiIn`,`dutyLoIn`} (high part in bits 9:2).
- R3: Steering 2'b00 (single): only channel A is enabled (`chOe`=4'b0001) and it carries the waveform.
- R4: Steering 2'b01 (forward bridge): all four channels are enabled. D carries the waveform, A is held active, and B and C are held inactive.
- R5: Steering 2'b10 (half bridge): only A and B are enabled (`chOe`=4'b0011). A is active with the waveform and B with its complement. Each turn-on is delayed by `deadIn` cycles, so per period A is active max(0,duty-`deadIn`) cycles and B max(0,period-duty-`deadIn`) cycles. If duty is 0 or at least the period length, the one steady channel is active for the whole period.
- R6: Steering 2'b11 (reverse bridge): all four channels are enabled. B carries the waveform, C is held active, and A and D are held inactive.
- R7: Polarity bit 1 makes A and C active-low and polarity bit 0 makes B and D active-low. Code 00 is all active-high, 01 gives B/D low, 10 gives A/C low and 11 is all active-low. Released channels output 0.
- R8: With `pwmEn` low (after two cycles of pipeline), `chOut[0]`=`ccpOut`, `chOe[0]`=`ccpOe`, and channels B to D are released.
- R9: Setting changes take effect only at a period start. A duty change made mid-period never produces more than one turn-on of the modulated channel within one period length.
- R10: In half-bridge steering, A and B are never logically active in the same cycle.
- R11: A duty of 0 keeps the modulated channel inactive. A duty at or above the period length keeps it active for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmEn | input | 1 | PWM operation on; low releases B to D and passes through A |
| periodIn | input | 8 | Timer period value (shadowed) |
| dutyHiIn | input | 8 | Duty bits 9:2 (shadowed) |
| dutyLoIn | input | 2 | Duty bits 1:0 (shadowed) |
| steerIn | input | 2 | Steering code (shadowed) |
| polIn | input | 2 | Polarity code; bit 1 for A/C, bit 0 for B/D (shadowed) |
| deadIn | input | 4 | Half-bridge turn-on delay in cycles (shadowed) |
| ccpOut | input | 1 | Capture/compare level for channel A when PWM is off |
| ccpOe | input | 1 | Capture/compare enable for channel A when PWM is off |
| chOut | output | 4 | Channel levels, bit 0 = A through bit 3 = D |
| chOe | output | 4 | Channel output enables, same bit order |

## Verification
A wrong internal value always shows at the ports within one period. A bad count or a stale working register changes how many cycles a channel is high in the next full period. A working register that loads mid-period shows as an extra turn-on within one period length of the write. A mis-steered or mis-polarised channel shows a wrong enable or a wrong static level two cycles after the period start that loads it. A dead-band counter that does not clear either overlaps A and B or shortens a pulse by a visible number of cycles in the first period after the settings load.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    STEER_SINGLE = 2'b00,
    STEER_FWD    = 2'b01,
    STEER_HALF   = 2'b10,
    STEER_REV    = 2'b11
  } steer_e;

  // strobes from the timing control to the datapath
  typedef struct packed {
    logic run;   // counter is running a period
    logic load;  // shadow values move to working registers this edge
  } strobe_t;
endpackage

// File: rtl/bps_ctrl.sv
module bps_ctrl
  import bps_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pwmEn,
  input  logic [TMR_W-1:0]         periodIn,
  output logic [TMR_W+FRAC_W-1:0]  cnt,
  output strobe_t                  strb
);
  localparam int CW = TMR_W + FRAC_W;

  logic [TMR_W-1:0]  tmrQ, perAct;
  logic [FRAC_W-1:0] fracQ;
  logic              started, atEnd, loadNow;

  assign atEnd   = (tmrQ == perAct) && (fracQ == {FRAC_W{1'b1}});
  assign loadNow = pwmEn && (!started || atEnd);
  assign cnt       = {tmrQ, fracQ};
  assign strb.run  = started;
  assign strb.load = loadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrQ    <= '0;
      fracQ   <= '0;
      started <= 1'b0;
      perAct  <= '0;
    end else if (!pwmEn) begin
      tmrQ    <= '0;
      fracQ   <= '0;
      started <= 1'b0;
    end else if (loadNow) begin
      tmrQ    <= '0;
      fracQ   <= '0;
      started <= 1'b1;
      perAct  <= periodIn;
    end else begin
      fracQ <= fracQ + 1'b1;
      if (fracQ == {FRAC_W{1'b1}}) tmrQ <= tmrQ + 1'b1;
    end
  end

  // count never passes the end of the working period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'({perAct, {FRAC_W{1'b1}}}));

  // disabled PWM parks the counter
  p_idle_park_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwmEn |=> (cnt == '0) && !strb.run);
endmodule

// File: rtl/bps_datapath.sv
module bps_datapath
  import bps_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DEAD_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [TMR_W+FRAC_W-1:0]  cnt,
  input  logic [TMR_W-1:0]         dutyHiIn,
  input  logic [FRAC_W-1:0]        dutyLoIn,
  input  steer_e                   steerIn,
  input  logic [1:0]               polIn,
  input  logic [DEAD_W-1:0]        deadIn,
  input  logic                     ccpOut,
  input  logic                     ccpOe,
  output logic [3:0]               chOut,
  output logic [3:0]               chOe
);
  localparam int CW = TMR_W + FRAC_W;

  // working copies, loaded at period start
  logic [CW-1:0]     dutyAct;
  steer_e            steerAct, steerQ, steerQ2;
  logic [1:0]        polAct, polQ, polQ2;
  logic [DEAD_W-1:0] deadAct, deadQ;

  logic       rawQ, runQ, runQ2;
  logic [3:0] lvlNx, oeNx, lvlQ, oeQ, actLvl, inv;
  logic [1:0] lvlHb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyAct  <= '0;
      steerAct <= STEER_SINGLE;
      polAct   <= '0;
      deadAct  <= '0;
    end else if (strb.load) begin
      dutyAct  <= {dutyHiIn, dutyLoIn};
      steerAct <= steerIn;
      polAct   <= polIn;
      deadAct  <= deadIn;
    end
  end

  // stage 1: compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ   <= 1'b0;
      runQ   <= 1'b0;
      steerQ <= STEER_SINGLE;
      polQ   <= '0;
      deadQ  <= '0;
    end else begin
      rawQ   <= strb.run && (cnt < dutyAct);
      runQ   <= strb.run;
      steerQ <= steerAct;
      polQ   <= polAct;
      deadQ  <= deadAct;
    end
  end

  // stage 2: steering
  always_comb begin
    lvlNx = '0;
    oeNx  = '0;
    if (runQ) begin
      case (steerQ)
        STEER_SINGLE: begin lvlNx[0] = rawQ; oeNx = 4'b0001; end
        STEER_FWD:    begin lvlNx = 4'b0001; lvlNx[3] = rawQ; oeNx = 4'b1111; end
        STEER_HALF:   oeNx = 4'b0011;
        default:      begin lvlNx = 4'b0100; lvlNx[1] = rawQ; oeNx = 4'b1111; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ    <= '0;
      oeQ     <= '0;
      runQ2   <= 1'b0;
      steerQ2 <= STEER_SINGLE;
      polQ2   <= '0;
    end else begin
      lvlQ    <= lvlNx;
      oeQ     <= oeNx;
      runQ2   <= runQ;
      steerQ2 <= steerQ;
      polQ2   <= polQ;
    end
  end

  // half-bridge turn-on delay, one cell per channel of the pair
  for (genvar g = 0; g < 2; g++) begin : gDead
    logic [DEAD_W-1:0] dlyQ;
    logic              actQ, want;
    assign want = runQ && (steerQ == STEER_HALF) && ((g == 0) ? rawQ : !rawQ);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyQ <= '0;
        actQ <= 1'b0;
      end else if (!want) begin
        dlyQ <= '0;
        actQ <= 1'b0;
      end else if (dlyQ >= deadQ) begin
        actQ <= 1'b1;
      end else begin
        dlyQ <= dlyQ + 1'b1;
      end
    end
    assign lvlHb[g] = actQ;
  end

  // polarity and release
  always_comb begin
    actLvl = (steerQ2 == STEER_HALF) ? {2'b00, lvlHb} : lvlQ;
    inv    = {polQ2[0], polQ2[1], polQ2[0], polQ2[1]};
    if (runQ2) begin
      chOe  = oeQ;
      chOut = (actLvl ^ inv) & oeQ;
    end else begin
      chOe  = {3'b000, ccpOe};
      chOut = {3'b000, ccpOut};
    end
  end

  // working values hold between period starts
  p_act_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dutyAct) && $stable(steerAct) && $stable(polAct));

  // complementary pair never both on
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (runQ2 && steerQ2 == STEER_HALF) |-> !(lvlHb[0] && lvlHb[1]));

  // forward bridge statics
  p_fwd_static_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runQ2 && steerQ2 == STEER_FWD) |-> (lvlQ[0] && !lvlQ[1] && !lvlQ[2]));
endmodule

// File: rtl/bridge_pwm_steer.sv
module bridge_pwm_steer
  import bps_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwmEn,
  input  logic [TMR_W-1:0]  periodIn,
  input  logic [TMR_W-1:0]  dutyHiIn,
  input  logic [FRAC_W-1:0] dutyLoIn,
  input  logic [1:0]        steerIn,
  input  logic [1:0]        polIn,
  input  logic [DEAD_W-1:0] deadIn,
  input  logic              ccpOut,
  input  logic              ccpOe,
  output logic [3:0]        chOut,
  output logic [3:0]        chOe
);
  localparam int CW = TMR_W + FRAC_W;

  strobe_t       strb;
  logic [CW-1:0] cnt;

  bps_ctrl #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwmEn(pwmEn), .periodIn(periodIn),
    .cnt(cnt), .strb(strb)
  );

  bps_datapath #(.TMR_W(TMR_W), .FRAC_W(FRAC_W), .DEAD_W(DEAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt),
    .dutyHiIn(dutyHiIn), .dutyLoIn(dutyLoIn), .steerIn(steer_e'(steerIn)),
    .polIn(polIn), .deadIn(deadIn), .ccpOut(ccpOut), .ccpOe(ccpOe),
    .chOut(chOut), .chOe(chOe)
  );
endmodule

// File: tb/bridge_pwm_steer_bench.sv
module bridge_pwm_steer_bench;
  logic       clk = 1'b0, rstN = 1'b0, pwmEn = 1'b0, ccpOut = 1'b0, ccpOe = 1'b0;
  logic [7:0] periodIn = '0, dutyHiIn = '0;
  logic [1:0] dutyLoIn = '0, steerIn = '0, polIn = '0;
  logic [3:0] deadIn = '0;
  logic [3:0] chOut, chOe;

  bridge_pwm_steer u_bridge_pwm_steer (
    .clk(clk), .rstN(rstN), .pwmEn(pwmEn), .periodIn(periodIn),
    .dutyHiIn(dutyHiIn), .dutyLoIn(dutyLoIn), .steerIn(steerIn),
    .polIn(polIn), .deadIn(deadIn), .ccpOut(ccpOut), .ccpOe(ccpOe),
    .chOut(chOut), .chOe(chOe)
  );

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0, curP = 4;
  bit finished = 0;
  int hiCnt[4], riseCnt[4], overlapCnt;
  logic [3:0] oeAnd, oeOr;

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expAct(int c, int st, int duty, int p, int dead);
    int d = (duty < p) ? duty : p;
    case (st)
      0: return (c == 0) ? d : 0;
      1: return (c == 0) ? p : ((c == 3) ? d : 0);
      2: begin
        if (c > 1) return 0;
        if (d >= p) return (c == 0) ? p : 0;
        if (d == 0) return (c == 1) ? p : 0;
        if (c == 0) return (d > dead) ? d - dead : 0;
        return ((p - d) > dead) ? p - d - dead : 0;
      end
      default: return (c == 1) ? d : ((c == 2) ? p : 0);
    endcase
  endfunction

  function automatic logic [3:0] expOe(int st);
    case (st)
      0: return 4'b0001;
      2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int expPhys(int c, int st, logic [1:0] pol, int duty, int p, int dead);
    logic [3:0] oe = expOe(st);
    logic inv = (c == 0 || c == 2) ? pol[1] : pol[0];
    int a = expAct(c, st, duty, p, dead);
    if (!oe[c]) return 0;
    return inv ? p - a : a;
  endfunction

  task automatic measure(int len, bit half, logic [1:0] pol);
    logic [3:0] prev;
    for (int c = 0; c < 4; c++) begin hiCnt[c] = 0; riseCnt[c] = 0; end
    overlapCnt = 0; oeAnd = '1; oeOr = '0;
    @(negedge clk);
    prev = chOut;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) begin
        if (chOut[c]) hiCnt[c]++;
        if (chOut[c] && !prev[c]) riseCnt[c]++;
      end
      oeAnd &= chOe;
      oeOr  |= chOe;
      if (half && (chOut[0] ^ pol[1]) && (chOut[1] ^ pol[0])) overlapCnt++;
      prev = chOut;
    end
  endtask

  task automatic apply(int per, int duty, int st, logic [1:0] pol, int dead);
    int newP = 4 * (per + 1);
    @(negedge clk);
    periodIn = per[7:0];
    dutyHiIn = duty[9:2];
    dutyLoIn = duty[1:0];
    steerIn  = st[1:0];
    polIn    = pol;
    deadIn   = dead[3:0];
    repeat (curP + newP + 8) @(negedge clk);
    curP = newP;
  endtask

  task automatic trial(string tag, int per, int duty, int st, logic [1:0] pol, int dead);
    int p = 4 * (per + 1);
    apply(per, duty, st, pol, dead);
    measure(p, st == 2, pol);
    for (int c = 0; c < 4; c++)
      check($sformatf("%s ch%0d high cycles", tag, c), hiCnt[c], expPhys(c, st, pol, duty, p, dead));
    check({tag, " enable steady"}, int'(oeAnd), int'(expOe(st)));
    check({tag, " enable set"}, int'(oeOr), int'(expOe(st)));
    if (st == 2) check("R10 half-bridge overlap cycles", overlapCnt, 0);
  endtask

  function automatic string stTag(int st, logic [1:0] pol);
    string s;
    case (st)
      0: s = "R3 single";
      1: s = "R4 forward";
      2: s = "R5 half";
      default: s = "R6 reverse";
    endcase
    if (pol != 2'b00) s = {s, " R7 polarity"};
    return s;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 oe during reset", int'(chOe), 0);
    check("R1 out during reset", int'(chOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 oe after reset", int'(chOe), 0);
    ccpOe = 1'b1; ccpOut = 1'b1; #1;
    check("R1 A pass-through after reset", int'({chOe, chOut}), 8'h11);
    ccpOe = 1'b0; ccpOut = 1'b0;

    @(negedge clk);
    pwmEn = 1'b1;
    curP = 4;

    // R2 duty assembly with fractional bits
    trial("R2 R3 duty", 9, 23, 0, 2'b00, 0);
    // R11 extremes
    trial("R11 zero duty", 9, 0, 0, 2'b00, 0);
    trial("R11 full duty", 254, 1023, 0, 2'b00, 0);
    trial("R11 R5 half full", 12, 60, 2, 2'b00, 5);
    trial("R11 R5 half zero", 12, 0, 2, 2'b01, 5);
    // directed steering
    trial("R4 forward", 15, 30, 1, 2'b00, 0);
    trial("R6 reverse R7", 15, 30, 3, 2'b11, 0);
    trial("R5 half dead", 20, 40, 2, 2'b10, 7);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      int per  = $urandom_range(3, 40);
      int p    = 4 * (per + 1);
      int duty = $urandom_range(0, p + 8);
      int st   = $urandom_range(0, 3);
      logic [1:0] pol = 2'($urandom_range(0, 3));
      int dead = $urandom_range(0, 15);
      if (duty > 1023) duty = 1023;
      trial(stTag(st, pol), per, duty, st, pol, dead);
    end

    // R9 mid-period duty changes
    trial("R9 base", 30, 40, 0, 2'b00, 0);
    for (int k = 0; k < 8; k++) begin
      int nd = (k % 2 == 0) ? 100 : 40;
      repeat ($urandom_range(0, 123)) @(negedge clk);
      dutyHiIn = nd[9:2];
      dutyLoIn = nd[1:0];
      measure(124, 1'b0, 2'b00);
      check("R9 turn-ons within one period", (riseCnt[0] <= 1) ? 1 : 0, 1);
      measure(124, 1'b0, 2'b00);
      check("R9 new duty after period start", hiCnt[0], nd);
    end

    // R8 PWM off pass-through
    @(negedge clk);
    pwmEn = 1'b0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ccpOut = 1'($urandom_range(0, 1));
      ccpOe  = 1'($urandom_range(0, 1));
      #1;
      check("R8 out pass-through", int'(chOut), int'({3'b000, ccpOut}));
      check("R8 oe pass-through", int'(chOe), int'({3'b000, ccpOe}));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule